// File: doc/BRIEF.md
# Burst Line Fill Controller

This block moves one whole cache line between a cache and external memory as a single four-word burst. The cache side gives a starting word address once, along with a read or write direction. The block then produces the addresses of the other three words itself. A read fills the line. A write sends a line out from the cache. The schedule is fixed at 2-1-1-1. The first word needs two clocks and each of the other words needs one clock, so a full line moves in five clocks. Four separate three-clock accesses would take twelve.

During a fill, each returned word goes into a line register at its offset within the line. The same word is also sent to the cache as a one-cycle stream beat. A `done` pulse marks the point where the complete line can be read. During a write-out, the block captures the line to be written when the request is accepted. It then drives that line to memory one word per beat, in the same address order a fill uses.

The address sequence starts at the requested word and wraps inside the line-aligned block. Only the word offset changes. The upper address bits stay fixed for the whole burst.

Top module: `burst_line_fill`

## Requirements
- R1: After reset, `busy`, `done`, `mem_start`, `mem_beat`, `mem_we` and `beat_valid` are 0, and `line_out` is all zeros.
- R2: A request is accepted on a rising edge where `req_valid` is 1 and `busy` is 0. After acceptance, `busy` is high for exactly five cycles. A `req_valid` that arrives while `busy` is high is ignored.
- R3: In the first cycle after acceptance, `mem_start` is high for one cycle and `mem_addr` equals the requested address. In the following four cycles, `mem_beat` is high. While idle, `mem_start`, `mem_beat` and `mem_we` are all 0.
- R4: The first word is transferred at the end of the second busy cycle. Each later word is transferred at the end of the next cycle. The whole burst therefore takes five clocks.
- R5: In beat k (k = 0..3), `mem_addr` keeps bits [AW-1:2] of the request address. Its low two bits are (request[1:0] + k) mod 4.
- R6: After a fill, line word i (bits [32i+31:32i] of `line_out`) holds the data memory returned for offset i. A write-out leaves `line_out` unchanged.
- R7: During a fill, `beat_valid` is high in the cycle after each word is transferred. In that cycle, `beat_data` carries the word and `beat_off` carries its offset. `beat_valid` stays 0 during write-outs.
- R8: `done` is a one-cycle pulse in the cycle after the fourth word is transferred. It coincides with `busy` returning to 0, and `line_out` already holds the complete line in that cycle.
- R9: During a write-out, `mem_we` is high for all five busy cycles. In each beat, `mem_wdata` equals word `beat offset` of the `req_wline` value captured at acceptance (bits [32i+31:32i]).
- R10: A request presented during the `done` cycle is accepted at the next edge, so two bursts can run back to back with a single idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Line transfer request |
| req_write | input | 1 | 1 = write line out, 0 = fill line |
| req_addr | input | AW | Starting word address |
| req_wline | input | LW*DW | Line to write; word i at bits [DW*i+DW-1:DW*i] |
| mem_rdata | input | DW | Word returned by memory |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| line_out | output | LW*DW | Assembled line, word i at offset i |
| beat_valid | output | 1 | Stream word valid (fills only) |
| beat_data | output | DW | Stream word |
| beat_off | output | $clog2(LW) | Offset of the stream word |
| mem_addr | output | AW | Memory word address |
| mem_start | output | 1 | Address strobe on the first beat only |
| mem_beat | output | 1 | Data moves at the end of this cycle |
| mem_we | output | 1 | Write direction to memory |
| mem_wdata | output | DW | Word written to memory |

## Verification
Take the edge that accepts the request as cycle 0 of the count. `mem_start` and the request address appear in the cycle right after that edge. `mem_beat` and the generated addresses follow in the next four cycles. Each stream beat appears one cycle after the edge that transfers its word. `done`, the fall of `busy` and the complete `line_out` all appear six cycles after acceptance.

The bench drives and samples only on falling edges. It steps one falling edge per cycle through each burst. At every step it compares each memory-side and cache-side output with the value that the cycle's position in this schedule predicts.

// File: rtl/bfl_pkg.sv
package bfl_pkg;

  // Address of a word k beats into a burst, wrapping inside a 2**ow word block.
  function automatic logic [31:0] wrap_word(input logic [31:0] base,
                                            input logic [31:0] k,
                                            input int unsigned ow);
    logic [31:0] m;
    m = (32'd1 << ow) - 32'd1;
    return (base & ~m) | ((base + k) & m);
  endfunction

  // Beat number carried by busy-cycle count c: cycle 0 and 1 both serve beat 0.
  function automatic logic [31:0] beat_of(input logic [31:0] c);
    return (c == 32'd0) ? 32'd0 : c - 32'd1;
  endfunction

endpackage

// File: rtl/bfl_sequencer.sv
module bfl_sequencer #(
  parameter int LW = 4,
  localparam int CW = $clog2(LW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  output logic          busy,
  output logic [CW-1:0] cnt,
  output logic          first_cyc,
  output logic          xfer,
  output logic          last_xfer,
  output logic          done
);

  assign first_cyc = busy && (cnt == '0);
  assign xfer      = busy && (cnt != '0);
  assign last_xfer = busy && (cnt == CW'(LW));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= last_xfer;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        if (last_xfer) begin
          busy <= 1'b0;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bfl_addr_gen.sv
module bfl_addr_gen #(
  parameter int AW = 16,
  parameter int LW = 4,
  localparam int OW = $clog2(LW),
  localparam int CW = $clog2(LW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic          busy,
  input  logic [CW-1:0] cnt,
  output logic [AW-1:0] mem_addr,
  output logic [OW-1:0] off
);

  logic [AW-1:0] base_q;
  logic [31:0]   full;

  always_ff @(posedge clk) begin
    if (!rst_n)      base_q <= '0;
    else if (accept) base_q <= req_addr;
  end

  always_comb begin
    full     = bfl_pkg::wrap_word(32'(base_q), bfl_pkg::beat_of(32'(cnt)), OW);
    off      = OW'(full);
    mem_addr = busy ? AW'(full) : '0;
  end

endmodule

// File: rtl/bfl_line_store.sv
module bfl_line_store #(
  parameter int DW = 32,
  parameter int LW = 4,
  localparam int OW = $clog2(LW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic           req_write,
  input  logic [LW*DW-1:0] req_wline,
  input  logic           busy,
  input  logic           xfer,
  input  logic [OW-1:0]  off,
  input  logic [DW-1:0]  mem_rdata,
  output logic           wr_q,
  output logic [LW*DW-1:0] line_out,
  output logic [DW-1:0]  wdata,
  output logic           beat_valid,
  output logic [DW-1:0]  beat_data,
  output logic [OW-1:0]  beat_off
);

  logic [DW-1:0] line_q  [LW];
  logic [DW-1:0] wline_q [LW];
  logic          fill_beat;

  assign fill_beat = xfer && !wr_q;
  assign wdata     = (busy && wr_q && xfer) ? wline_q[off] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q       <= 1'b0;
      beat_valid <= 1'b0;
      beat_data  <= '0;
      beat_off   <= '0;
      for (int i = 0; i < LW; i++) begin
        line_q[i]  <= '0;
        wline_q[i] <= '0;
      end
    end else begin
      beat_valid <= fill_beat;
      if (fill_beat) begin
        line_q[off] <= mem_rdata;
        beat_data   <= mem_rdata;
        beat_off    <= off;
      end
      if (accept) begin
        wr_q <= req_write;
        if (req_write) begin
          for (int i = 0; i < LW; i++) wline_q[i] <= req_wline[i*DW +: DW];
        end
      end
    end
  end

  for (genvar g = 0; g < LW; g++) begin : g_flat
    assign line_out[g*DW +: DW] = line_q[g];
  end

endmodule

// File: rtl/burst_line_fill.sv
module burst_line_fill #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int LW = 4,
  localparam int OW = $clog2(LW),
  localparam int CW = $clog2(LW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [LW*DW-1:0] req_wline,
  input  logic [DW-1:0]    mem_rdata,
  output logic             busy,
  output logic             done,
  output logic [LW*DW-1:0] line_out,
  output logic             beat_valid,
  output logic [DW-1:0]    beat_data,
  output logic [OW-1:0]    beat_off,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_start,
  output logic             mem_beat,
  output logic             mem_we,
  output logic [DW-1:0]    mem_wdata
);

  logic          accept;
  logic [CW-1:0] cnt;
  logic          first_cyc;
  logic          xfer;
  logic          last_xfer;
  logic [OW-1:0] off;
  logic          wr_q;

  assign accept    = req_valid && !busy;
  assign mem_start = first_cyc;
  assign mem_beat  = xfer;
  assign mem_we    = busy && wr_q;

  bfl_sequencer #(.LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy), .cnt(cnt),
    .first_cyc(first_cyc), .xfer(xfer), .last_xfer(last_xfer), .done(done)
  );

  bfl_addr_gen #(.AW(AW), .LW(LW)) u_addr (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
    .busy(busy), .cnt(cnt), .mem_addr(mem_addr), .off(off)
  );

  bfl_line_store #(.DW(DW), .LW(LW)) u_store (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_write(req_write),
    .req_wline(req_wline), .busy(busy), .xfer(xfer), .off(off),
    .mem_rdata(mem_rdata), .wr_q(wr_q), .line_out(line_out), .wdata(mem_wdata),
    .beat_valid(beat_valid), .beat_data(beat_data), .beat_off(beat_off)
  );

endmodule

// File: rtl/bfl_checker.sv
module bfl_checker #(
  parameter int AW = 16,
  parameter int LW = 4,
  localparam int OW = $clog2(LW)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          done,
  input logic          mem_start,
  input logic          mem_beat,
  input logic          mem_we,
  input logic          beat_valid,
  input logic [AW-1:0] mem_addr
);

  logic [7:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n) run_len <= '0;
    else        run_len <= busy ? run_len + 8'd1 : 8'd0;
  end

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == 8'(LW + 1)));

  p_ignore_while_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && busy) |=> !mem_start);

  p_start_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> (mem_start && busy));

  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_start |=> (!mem_start && mem_beat));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_start && !mem_beat && !mem_we));

  p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_beat |-> (mem_addr[AW-1:OW] == $past(mem_addr[AW-1:OW])));

  p_stream_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> $past(mem_beat && !mem_we));

  p_done_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(mem_beat)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind burst_line_fill bfl_checker #(.AW(AW), .LW(LW)) u_bfl_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .mem_start(mem_start), .mem_beat(mem_beat), .mem_we(mem_we),
  .beat_valid(beat_valid), .mem_addr(mem_addr)
);

// File: tb/tb_burst_line_fill.sv
module tb_burst_line_fill;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW*DW-1:0] req_wline = '0;
  logic [DW-1:0] mem_rdata;
  logic busy, done, beat_valid, mem_start, mem_beat, mem_we;
  logic [LW*DW-1:0] line_out;
  logic [DW-1:0] beat_data, mem_wdata;
  logic [1:0] beat_off;
  logic [AW-1:0] mem_addr;

  int errors = 0;
  int checks = 0;
  logic [LW*DW-1:0] exp_line = '0;
  logic nx_valid = 1'b0, nx_write = 1'b0;
  logic [AW-1:0] nx_addr = '0;

  always #10 clk = ~clk;

  burst_line_fill dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wline(req_wline), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .line_out(line_out), .beat_valid(beat_valid),
    .beat_data(beat_data), .beat_off(beat_off), .mem_addr(mem_addr),
    .mem_start(mem_start), .mem_beat(mem_beat), .mem_we(mem_we),
    .mem_wdata(mem_wdata)
  );

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return {a ^ 16'h5A3C, a};
  endfunction

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] a, input int k);
    return {a[AW-1:2], 2'(a[1:0] + 2'(k))};
  endfunction

  assign mem_rdata = memf(mem_addr);

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Issue at a falling edge, then step through the five busy cycles and the done cycle.
  task automatic run_burst(input logic wr, input logic [AW-1:0] a,
                           input logic [LW*DW-1:0] wl, input bit noise, input bit chain);
    logic [AW-1:0] ba;
    int k;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wline = wl;
    @(posedge clk); @(negedge clk);
    req_valid = noise; req_addr = ~a; req_write = ~wr; req_wline = ~wl;
    for (int c = 0; c < 5; c++) begin
      k  = (c == 0) ? 0 : c - 1;
      ba = beat_addr(a, k);
      chk(busy == 1'b1, "R2 busy", 128'(busy), 128'd1);
      chk(mem_start == (c == 0), "R3 mem_start", 128'(mem_start), 128'(c == 0));
      chk(mem_beat == (c != 0), "R4 mem_beat", 128'(mem_beat), 128'(c != 0));
      chk(mem_addr == ba, "R5 mem_addr", 128'(mem_addr), 128'(ba));
      chk(mem_we == wr, "R9 mem_we", 128'(mem_we), 128'(wr));
      if (wr && c != 0)
        chk(mem_wdata == wl[ba[1:0]*DW +: DW], "R9 mem_wdata", 128'(mem_wdata),
            128'(wl[ba[1:0]*DW +: DW]));
      if (!wr && c != 0) exp_line[ba[1:0]*DW +: DW] = memf(ba);
      if (!wr && c >= 2) begin
        chk(beat_valid && beat_data == memf(beat_addr(a, c - 2)) &&
            beat_off == beat_addr(a, c - 2)%4, "R7 stream", 128'({beat_valid, beat_off, beat_data}),
            128'({1'b1, 2'(beat_addr(a, c - 2)), memf(beat_addr(a, c - 2))}));
      end else begin
        chk(beat_valid == 1'b0, "R7 stream idle", 128'(beat_valid), 128'd0);
      end
      if (c == 4) begin
        if (chain) begin
          req_valid = nx_valid; req_write = nx_write; req_addr = nx_addr;
        end else begin
          req_valid = 1'b0;
        end
      end
      @(negedge clk);
    end
    chk(done == 1'b1 && busy == 1'b0, "R8 done/busy", 128'({done, busy}), 128'b10);
    chk(line_out == exp_line, "R6/R8 line_out", line_out, exp_line);
    if (!wr)
      chk(beat_valid && beat_data == memf(beat_addr(a, 3)), "R7 last beat",
          128'({beat_valid, beat_data}), 128'({1'b1, memf(beat_addr(a, 3))}));
    else
      chk(beat_valid == 1'b0, "R7 no stream on write", 128'(beat_valid), 128'd0);
    if (!chain) begin
      @(negedge clk);
      chk(done == 1'b0, "R8 done one cycle", 128'(done), 128'd0);
    end
  endtask

  task automatic t_reset();
    chk(!busy && !done && !mem_start && !mem_beat && !mem_we && !beat_valid,
        "R1 reset controls", 128'({busy, done, mem_start, mem_beat, mem_we, beat_valid}), 128'd0);
    chk(line_out == '0, "R1 reset line", line_out, 128'd0);
  endtask

  task automatic t_read_aligned();
    run_burst(1'b0, 16'h1230, '0, 1'b0, 1'b0);
  endtask

  task automatic t_read_wrap();
    run_burst(1'b0, 16'h4C46, '0, 1'b0, 1'b0);
  endtask

  task automatic t_ignore_busy();
    run_burst(1'b0, 16'h0A0B, '0, 1'b1, 1'b0);
    chk(busy == 1'b0, "R2 ignored request not taken", 128'(busy), 128'd0);
  endtask

  task automatic t_write();
    run_burst(1'b1, 16'h7771, 128'h44444444_33333333_22222222_11111111, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk(line_out == exp_line && !mem_we, "R6 line held after write", line_out, exp_line);
  endtask

  task automatic t_chain();
    nx_valid = 1'b1; nx_write = 1'b0; nx_addr = 16'hFFFF;
    run_burst(1'b0, 16'h8001, '0, 1'b0, 1'b1);
    run_burst(1'b0, 16'hFFFF, '0, 1'b0, 1'b0);
    chk(1'b1, "R10 back-to-back", 128'd0, 128'd0);
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_aligned();
    t_read_wrap();
    t_ignore_busy();
    t_write();
    t_chain();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule